// File: doc/BRIEF.md
# Randomized Region Remap Engine

This block sits between a requester and a wear-limited block memory and hides where each physical block really lives. The physical address space is cut into regions of R blocks. A small table holds, for every physical region, a memory region number and an in-region displacement. A request is translated by replacing its region bits with the table's target and XORing its block offset with the displacement, so translation is one table read and one XOR, with no clock in the path.

On an accepted write, a slice of the random input is compared against a threshold. When the comparison hits, the engine swaps the translations of the written region and a partner region that another random slice picks. It then issues a fixed sequence of block-move commands: R reads of each of the two memory regions, then R writes to each. After the last write is accepted, it rewrites both table entries in one cycle, exchanging the targets and XORing each displacement with fresh random bits.

While a swap runs, requests to the two regions involved are held off. All other traffic keeps flowing through the unchanged table.

Top module: `rmap_engine`

## Requirements
- R1: `xl_addr` equals the entry's target region in the upper REG_BITS bits, followed by the request's block offset XOR the entry's displacement in the lower OFF_BITS bits. It is combinational from `req_addr`, and a translated request is accepted in the cycle where `req_valid` and `req_ready` are both high.
- R2: After reset every region maps to itself with displacement zero, `mv_valid` is low and `req_ready` is high.
- R3: A read request (`req_write` low) never starts a swap, whatever `rnd_in` holds.
- R4: An accepted write while idle starts a swap when `rnd_in[TRIG_W-1:0]` is below TRIG_THRESH. `mv_valid` rises in the next cycle. No write count is kept.
- R5: A swap of physical region A (the written one) with partner B = `rnd_in[TRIG_W +: REG_BITS]` issues 4R commands, with offsets 0..R-1 in each phase, in this order: reads of A's old target, reads of B's old target, writes to B's old target, writes to A's old target. `mv_write` is 1 only in the write phases. Each command advances only when `mv_ready` is high.
- R6: While `mv_valid` is high and `mv_ready` is low, `mv_addr` and `mv_write` hold their values.
- R7: While a swap is running, a request whose region is A or B sees `req_ready` low.
- R8: When a swap with A different from B completes, A takes B's old target and B takes A's old target. A's displacement is XORed with `rnd_in[TRIG_W+REG_BITS +: OFF_BITS]` and B's displacement with the next OFF_BITS bits, both sampled when the swap starts.
- R9: When B equals A, only A's displacement changes. All 4R commands are still issued.
- R10: The table is always a one-to-one map between physical and memory regions.
- R11: The table update occurs at the same clock edge that accepts the last write command. Requests in the following cycle see the new mapping, and `mv_valid` is low in that cycle.
- R12: During a swap, requests to any region other than A and B are accepted and translated with the current table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | Request is a write |
| req_addr | input | REG_BITS+OFF_BITS | Physical block address |
| req_ready | output | 1 | Request accepted this cycle |
| xl_addr | output | REG_BITS+OFF_BITS | Translated memory block address |
| mv_valid | output | 1 | Block-move command present |
| mv_write | output | 1 | Command is a block write (else a read) |
| mv_addr | output | REG_BITS+OFF_BITS | Memory block address of the command |
| mv_ready | input | 1 | Memory accepts the command |
| rnd_in | input | TRIG_W+REG_BITS+2*OFF_BITS | Random bits: trigger, partner, two displacement salts |

## Verification
A corrupted table entry shows up on `xl_addr` at the first request to that region. A lost or duplicated target also breaks the one-to-one property, and this is detectable as soon as all regions are probed. A sequencer that slips a phase or an index produces a wrong `mv_addr` or `mv_write` on the very command where it goes wrong. An update applied one edge early or late shows up on the first request after the last write. The bench therefore compares `req_ready`, `xl_addr` and the move port against its model in every cycle, so most faults are caught within one cycle of becoming visible.

// File: rtl/rmap_pkg.sv
package rmap_pkg;

   // Move phases; the order is the command order of a swap.
   typedef enum logic [1:0] {
      PH_RD_A = 2'd0,
      PH_RD_B = 2'd1,
      PH_WR_B = 2'd2,
      PH_WR_A = 2'd3
   } move_ph_t;

   function automatic logic ph_is_write(move_ph_t ph);
      return (ph == PH_WR_B) || (ph == PH_WR_A);
   endfunction

   function automatic logic ph_uses_a(move_ph_t ph);
      return (ph == PH_RD_A) || (ph == PH_WR_A);
   endfunction

endpackage

// File: rtl/rmap_table.sv
module rmap_table #(
   parameter int REG_BITS = 3,
   parameter int OFF_BITS = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [REG_BITS-1:0]          lk_reg,
   input  logic [OFF_BITS-1:0]          lk_off,
   output logic [REG_BITS+OFF_BITS-1:0] lk_addr,
   input  logic [REG_BITS-1:0]          pk_reg,
   output logic [REG_BITS-1:0]          pk_tgt,
   input  logic                         upd_en,
   input  logic [REG_BITS-1:0]          upd_a,
   input  logic [REG_BITS-1:0]          upd_b,
   input  logic [REG_BITS-1:0]          upd_tgt_a,
   input  logic [REG_BITS-1:0]          upd_tgt_b,
   input  logic [OFF_BITS-1:0]          upd_rnd_a,
   input  logic [OFF_BITS-1:0]          upd_rnd_b
);

   localparam int NREG = 1 << REG_BITS;

   if (REG_BITS < 1 || REG_BITS > 10) begin : g_bad_reg
      $error("rmap_table: REG_BITS out of range");
   end
   if (OFF_BITS < 1) begin : g_bad_off
      $error("rmap_table: OFF_BITS must be at least 1");
   end

   logic [NREG*REG_BITS-1:0] tgt_flat;
   logic [NREG*OFF_BITS-1:0] disp_flat;

   for (genvar e = 0; e < NREG; e++) begin : g_ent
      logic [REG_BITS-1:0] tgt_q;
      logic [OFF_BITS-1:0] disp_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tgt_q  <= REG_BITS'(e);
            disp_q <= '0;
         end else if (upd_en) begin
            if (upd_a == REG_BITS'(e)) begin
               tgt_q  <= upd_tgt_a;
               disp_q <= disp_q ^ upd_rnd_a;
            end else if (upd_b == REG_BITS'(e)) begin
               tgt_q  <= upd_tgt_b;
               disp_q <= disp_q ^ upd_rnd_b;
            end
         end
      end

      assign tgt_flat[e*REG_BITS +: REG_BITS]  = tgt_q;
      assign disp_flat[e*OFF_BITS +: OFF_BITS] = disp_q;
   end

   assign lk_addr = {tgt_flat[lk_reg*REG_BITS +: REG_BITS],
                     lk_off ^ disp_flat[lk_reg*OFF_BITS +: OFF_BITS]};
   assign pk_tgt  = tgt_flat[pk_reg*REG_BITS +: REG_BITS];

   // Occupancy of memory regions, for the one-to-one check.
   logic [NREG-1:0] tgt_mask;
   always_comb begin
      tgt_mask = '0;
      for (int e = 0; e < NREG; e++) begin
         tgt_mask[tgt_flat[e*REG_BITS +: REG_BITS]] = 1'b1;
      end
   end

   // R10: every memory region is owned by exactly one physical region.
   p_bijective_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tgt_mask) == NREG);

   // R9: a self-swap leaves every target where it was.
   p_self_keeps_tgt_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && upd_a == upd_b) |=> $stable(tgt_flat));

endmodule

// File: rtl/rmap_trigger.sv
module rmap_trigger #(
   parameter int TRIG_W      = 6,
   parameter int TRIG_THRESH = 3
) (
   input  logic              wr_fire,
   input  logic [TRIG_W-1:0] trig_rnd,
   output logic              start
);

   localparam logic [TRIG_W:0] THRESH_V = (TRIG_W+1)'(TRIG_THRESH);

   if (TRIG_W < 1 || TRIG_W > 30) begin : g_bad_w
      $error("rmap_trigger: TRIG_W out of range");
   end
   if (TRIG_THRESH < 0 || TRIG_THRESH > (1 << TRIG_W)) begin : g_bad_th
      $error("rmap_trigger: TRIG_THRESH out of range");
   end

   // Memoryless draw: probability TRIG_THRESH / 2**TRIG_W per write.
   assign start = wr_fire && ({1'b0, trig_rnd} < THRESH_V);

endmodule

// File: rtl/rmap_mover.sv
module rmap_mover
   import rmap_pkg::*;
#(
   parameter int REG_BITS = 3,
   parameter int OFF_BITS = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic [REG_BITS-1:0]          a_reg,
   input  logic [REG_BITS-1:0]          b_reg,
   input  logic [REG_BITS-1:0]          a_tgt,
   input  logic [REG_BITS-1:0]          b_tgt,
   input  logic [OFF_BITS-1:0]          a_rnd,
   input  logic [OFF_BITS-1:0]          b_rnd,
   input  logic                         mv_ready,
   output logic                         busy,
   output logic [REG_BITS-1:0]          lock_a,
   output logic [REG_BITS-1:0]          lock_b,
   output logic                         mv_valid,
   output logic                         mv_write,
   output logic [REG_BITS+OFF_BITS-1:0] mv_addr,
   output logic                         upd_en,
   output logic [REG_BITS-1:0]          upd_a,
   output logic [REG_BITS-1:0]          upd_b,
   output logic [REG_BITS-1:0]          upd_tgt_a,
   output logic [REG_BITS-1:0]          upd_tgt_b,
   output logic [OFF_BITS-1:0]          upd_rnd_a,
   output logic [OFF_BITS-1:0]          upd_rnd_b
);

   logic                busy_q;
   move_ph_t            ph_q;
   logic [OFF_BITS-1:0] ix_q;
   logic [REG_BITS-1:0] a_q, b_q, ta_q, tb_q;
   logic [OFF_BITS-1:0] ra_q, rb_q;
   logic                step, blk_last;

   assign step     = busy_q && mv_ready;
   assign blk_last = &ix_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         ph_q   <= PH_RD_A;
         ix_q   <= '0;
         a_q    <= '0;
         b_q    <= '0;
         ta_q   <= '0;
         tb_q   <= '0;
         ra_q   <= '0;
         rb_q   <= '0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q <= 1'b1;
            ph_q   <= PH_RD_A;
            ix_q   <= '0;
            a_q    <= a_reg;
            b_q    <= b_reg;
            ta_q   <= a_tgt;
            tb_q   <= b_tgt;
            ra_q   <= a_rnd;
            rb_q   <= b_rnd;
         end
      end else if (step) begin
         ix_q <= ix_q + 1'b1;
         if (blk_last) begin
            if (ph_q == PH_WR_A) begin
               busy_q <= 1'b0;
            end else begin
               ph_q <= move_ph_t'(ph_q + 2'd1);
            end
         end
      end
   end

   assign busy      = busy_q;
   assign lock_a    = a_q;
   assign lock_b    = b_q;
   assign mv_valid  = busy_q;
   assign mv_write  = ph_is_write(ph_q);
   assign mv_addr   = {ph_uses_a(ph_q) ? ta_q : tb_q, ix_q};

   assign upd_en    = step && blk_last && (ph_q == PH_WR_A);
   assign upd_a     = a_q;
   assign upd_b     = b_q;
   assign upd_tgt_a = tb_q;
   assign upd_tgt_b = ta_q;
   assign upd_rnd_a = ra_q;
   assign upd_rnd_b = rb_q;

   // R6: an unaccepted command is held unchanged.
   p_hold_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mv_valid && !mv_ready) |=> (mv_valid && $stable(mv_addr) && $stable(mv_write)));

   // R5: the block after the last of a phase starts the next phase at offset 0.
   p_phase_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && blk_last && ph_q != PH_WR_A) |=> (ph_q != $past(ph_q) && ix_q == '0 && busy_q));

   // R5: reads never follow a write inside one swap.
   p_no_read_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && mv_write) |=> (!busy_q || mv_write));

endmodule

// File: rtl/rmap_engine.sv
module rmap_engine #(
   parameter int REG_BITS    = 3,
   parameter int OFF_BITS    = 2,
   parameter int TRIG_W      = 6,
   parameter int TRIG_THRESH = 3
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic                                      req_valid,
   input  logic                                      req_write,
   input  logic [REG_BITS+OFF_BITS-1:0]              req_addr,
   output logic                                      req_ready,
   output logic [REG_BITS+OFF_BITS-1:0]              xl_addr,
   output logic                                      mv_valid,
   output logic                                      mv_write,
   output logic [REG_BITS+OFF_BITS-1:0]              mv_addr,
   input  logic                                      mv_ready,
   input  logic [TRIG_W+REG_BITS+2*OFF_BITS-1:0]     rnd_in
);

   localparam int AW = REG_BITS + OFF_BITS;

   logic [REG_BITS-1:0] req_reg, pick_reg, pk_tgt, lock_a, lock_b;
   logic [OFF_BITS-1:0] req_off, salt_a, salt_b;
   logic [TRIG_W-1:0]   trig_rnd;
   logic [AW-1:0]       lk_addr;
   logic                busy, wr_fire, start;
   logic                upd_en;
   logic [REG_BITS-1:0] upd_a, upd_b, upd_tgt_a, upd_tgt_b;
   logic [OFF_BITS-1:0] upd_rnd_a, upd_rnd_b;

   assign req_reg  = req_addr[AW-1:OFF_BITS];
   assign req_off  = req_addr[OFF_BITS-1:0];
   assign trig_rnd = rnd_in[TRIG_W-1:0];
   assign pick_reg = rnd_in[TRIG_W +: REG_BITS];
   assign salt_a   = rnd_in[TRIG_W+REG_BITS +: OFF_BITS];
   assign salt_b   = rnd_in[TRIG_W+REG_BITS+OFF_BITS +: OFF_BITS];

   assign req_ready = !(busy && (req_reg == lock_a || req_reg == lock_b));
   assign wr_fire   = req_valid && req_write && req_ready && !busy;
   assign xl_addr   = lk_addr;

   rmap_table #(.REG_BITS(REG_BITS), .OFF_BITS(OFF_BITS)) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_reg    (req_reg),
      .lk_off    (req_off),
      .lk_addr   (lk_addr),
      .pk_reg    (pick_reg),
      .pk_tgt    (pk_tgt),
      .upd_en    (upd_en),
      .upd_a     (upd_a),
      .upd_b     (upd_b),
      .upd_tgt_a (upd_tgt_a),
      .upd_tgt_b (upd_tgt_b),
      .upd_rnd_a (upd_rnd_a),
      .upd_rnd_b (upd_rnd_b)
   );

   rmap_trigger #(.TRIG_W(TRIG_W), .TRIG_THRESH(TRIG_THRESH)) u_trig (
      .wr_fire  (wr_fire),
      .trig_rnd (trig_rnd),
      .start    (start)
   );

   rmap_mover #(.REG_BITS(REG_BITS), .OFF_BITS(OFF_BITS)) u_mover (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .a_reg     (req_reg),
      .b_reg     (pick_reg),
      .a_tgt     (lk_addr[AW-1:OFF_BITS]),
      .b_tgt     (pk_tgt),
      .a_rnd     (salt_a),
      .b_rnd     (salt_b),
      .mv_ready  (mv_ready),
      .busy      (busy),
      .lock_a    (lock_a),
      .lock_b    (lock_b),
      .mv_valid  (mv_valid),
      .mv_write  (mv_write),
      .mv_addr   (mv_addr),
      .upd_en    (upd_en),
      .upd_a     (upd_a),
      .upd_b     (upd_b),
      .upd_tgt_a (upd_tgt_a),
      .upd_tgt_b (upd_tgt_b),
      .upd_rnd_a (upd_rnd_a),
      .upd_rnd_b (upd_rnd_b)
   );

   // R3/R4: a swap only ever begins right after an accepted write.
   p_start_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mv_valid) |-> $past(req_valid && req_write && req_ready));

   // R11: a swap ends only on the edge that accepted a write command.
   p_end_on_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mv_valid) |-> $past(mv_valid && mv_ready && mv_write));

   // R7: the written region of an active swap is never handed out.
   p_lock_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mv_valid && req_valid && req_reg == lock_a) |-> !req_ready);

endmodule

// File: tb/test_rmap_engine.sv
`timescale 1ns/1ps
module test_rmap_engine;

   localparam int RB   = 3;
   localparam int OB   = 2;
   localparam int TW   = 6;
   localparam int TH   = 3;
   localparam int NREG = 1 << RB;
   localparam int R    = 1 << OB;
   localparam int AW   = RB + OB;
   localparam int RW   = TW + RB + 2*OB;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0, mv_ready = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [RW-1:0] rnd_in = '0;
   logic req_ready, mv_valid, mv_write;
   logic [AW-1:0] xl_addr, mv_addr;

   always #5 clk = ~clk;

   rmap_engine #(.REG_BITS(RB), .OFF_BITS(OB), .TRIG_W(TW), .TRIG_THRESH(TH)) i_rmap_engine (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_ready(req_ready), .xl_addr(xl_addr),
      .mv_valid(mv_valid), .mv_write(mv_write), .mv_addr(mv_addr),
      .mv_ready(mv_ready), .rnd_in(rnd_in)
   );

   int n_cmp = 0;
   int n_bad = 0;

   // Reference model state (value after the most recent modelled edge).
   int mt[NREG];
   int md[NREG];
   bit busy = 0;
   int ma, mb, ta, tb, ra, rb, ph, ix;

   // Outputs seen in the last step.
   int last_xl, last_ready, last_mvv, last_mva, last_mvw;

   task automatic check(string tag, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int enc(int rg, int off);
      return (rg << OB) | off;
   endfunction

   function automatic int rfield(int rt, int pick, int sa, int sb);
      return rt | (pick << TW) | (sa << (TW+RB)) | (sb << (TW+RB+OB));
   endfunction

   task automatic step(bit v, bit w, int addr, int rnd, bit mr);
      int rg, off, exp_rdy;
      bit was_busy;
      @(negedge clk);
      req_valid = v;
      req_write = w;
      req_addr  = AW'(addr);
      rnd_in    = RW'(rnd);
      mv_ready  = mr;
      #1;
      rg  = (addr >> OB) % NREG;
      off = addr % R;
      exp_rdy = (busy && (rg == ma || rg == mb)) ? 0 : 1;
      last_xl = int'(xl_addr); last_ready = int'(req_ready);
      last_mvv = int'(mv_valid); last_mva = int'(mv_addr); last_mvw = int'(mv_write);
      // R7 / R12: stall only on the two swapping regions
      check("R7 req_ready", last_ready, exp_rdy);
      if (v && exp_rdy == 1) check("R1 xl_addr", last_xl, enc(mt[rg], off ^ md[rg]));
      check("R4 mv_valid", last_mvv, int'(busy));
      if (busy) begin
         check("R5 mv_write", last_mvw, (ph >= 2) ? 1 : 0);
         check("R5 mv_addr", last_mva, enc((ph == 0 || ph == 3) ? ta : tb, ix));
      end
      // advance model to the state after the coming edge (R11 timing)
      was_busy = busy;
      if (was_busy && mr) begin
         if (ix == R-1) begin
            ix = 0;
            if (ph == 3) begin
               busy = 0;
               if (ma == mb) begin
                  md[ma] ^= ra;
               end else begin
                  int t;
                  t = mt[ma]; mt[ma] = mt[mb]; mt[mb] = t;
                  md[ma] ^= ra; md[mb] ^= rb;
               end
            end else ph++;
         end else ix++;
      end
      if (!was_busy && v && w && exp_rdy == 1 && (rnd % (1 << TW)) < TH) begin
         busy = 1; ph = 0; ix = 0;
         ma = rg;
         mb = (rnd >> TW) % NREG;
         ta = mt[ma]; tb = mt[mb];
         ra = (rnd >> (TW+RB)) % R;
         rb = (rnd >> (TW+RB+OB)) % R;
      end
   endtask

   task automatic drain();
      while (busy) step(0, 0, 0, 0, 1);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < NREG; i++) begin mt[i] = i; md[i] = 0; end
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // R2: reset state
      @(negedge clk); #1;
      check("R2 mv_valid", int'(mv_valid), 0);
      check("R2 req_ready", int'(req_ready), 1);

      // R2 identity map; R3 reads with a hitting draw never start a swap
      for (int a = 0; a < NREG*R; a++) begin
         step(1, 0, a, rfield(0, 5, 1, 1), 1);
         check("R2 identity", last_xl, a);
      end
      step(0, 0, 0, 0, 1);
      check("R3 no swap on reads", last_mvv, 0);

      // R9: self-swap of region 2, salt 3
      step(1, 1, enc(2, 1), rfield(0, 2, 3, 1), 1);
      step(1, 0, enc(2, 0), 0, 1);
      check("R7 stall own region", last_ready, 0);
      step(1, 0, enc(5, 1), 0, 1);
      check("R12 other region ready", last_ready, 1);
      check("R12 other region xl", last_xl, enc(5, 1));
      begin
         int held;
         step(0, 0, 0, 0, 0);
         held = last_mva;
         step(0, 0, 0, 0, 0);
         check("R6 held addr", last_mva, held);
         step(0, 0, 0, 0, 0);
         check("R6 held addr", last_mva, held);
      end
      drain();
      step(1, 0, enc(2, 0), 0, 1);
      check("R9 self swap", last_xl, enc(2, 3));

      // R8 / R11: swap region 1 with region 6
      step(1, 1, enc(1, 0), rfield(1, 6, 1, 2), 1);
      step(1, 0, enc(6, 0), 0, 1);
      check("R7 stall partner", last_ready, 0);
      drain();
      step(1, 0, enc(1, 0), 0, 1);
      check("R11 new map next cycle", last_xl, enc(6, 1));
      check("R11 mv idle", last_mvv, 0);
      step(1, 0, enc(6, 0), 0, 1);
      check("R8 partner swapped", last_xl, enc(1, 2));

      // random traffic
      for (int i = 0; i < 5000; i++) begin
         step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
              int'($urandom_range(0, NREG*R-1)), int'($urandom_range(0, (1 << RW) - 1)),
              $urandom_range(0, 3) != 0);
      end
      drain();

      // R10: targets form a permutation
      begin
         int seen = 0;
         for (int g = 0; g < NREG; g++) begin
            step(1, 0, enc(g, 0), 0, 1);
            seen |= 1 << (last_xl >> OB);
         end
         check("R10 one-to-one", seen, (1 << NREG) - 1);
      end

      summary();
      $finish;
   end

endmodule